// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block is the clocked read engine behind a memory bus interface. It holds a small read configuration register, written through a two-step command sequence on the same bus. The register selects between a plain one-word-per-clock read mode and a synchronous burst mode. In burst mode it also sets the word order, the burst length and the number of clocks before the first word.

After reset the block is in the plain read mode. Once burst mode is configured, a read starts by capturing a start address in one of two ways, whichever comes first:

- on the first clock edge that samples the address-valid strobe low;
- on the rising edge of that strobe, if no clock edge saw it low.

From the captured address the block walks the storage array and presents one word per clock after the latency has elapsed. Accesses flagged as auxiliary space (identifier, status or parameter regions) return a single word and never burst.

Deselecting the chip stops any burst at once and turns the data outputs off. The storage array sits outside the block. The block drives its address and registers the word that comes back.

Top module: `burst_read_seq`

## Requirements
- R1: After reset the data output enable `dout_en` is low and the block is in plain read mode (configuration bit 0 cleared).
- R2: The configuration changes only when two write cycles follow each other. A write cycle is a clock edge sampling `sel_n` low, `we_n` low and `oe_n` high. The first write carries `wdata` 0x60 and the second carries `wdata` 0x03. The second write loads `addr[6:0]`, with these fields: bit 0 = burst mode, bit 1 = interleaved order, bits 3:2 = length (00 four, 01 eight, 1x continuous), bits 6:4 = latency. Any other second write leaves the configuration unchanged.
- R3: In plain read mode, every clock edge with `sel_n` low and `we_n` high registers the word at `addr`. It is presented from that edge on, and no burst ever runs.
- R4: In burst mode the start address is taken on the first clock edge that samples `adv_n` low (with `sel_n` low and `we_n` high). Later edges of the same low phase do not restart the burst.
- R5: If `adv_n` goes low and back high between two clock edges, the address present at its rising edge is used. The burst starts at the next clock edge.
- R6: The first word of a burst appears after the edge that lies L edges after the capture edge. L is the latency field, clamped to the range 2..6.
- R7: In a linear fixed burst of N words (4 or 8), word k comes from the start address plus k. The low log2(N) bits wrap within the N-aligned block.
- R8: In an interleaved fixed burst, the low log2(N) bits of word k are the start offset XOR k, and the upper bits stay those of the start address.
- R9: In a continuous burst, word k comes from the start address plus k, crossing block boundaries without wrapping.
- R10: A fixed burst delivers exactly N words, after which `dout_en` goes low while the chip stays selected.
- R11: Raising `sel_n` drops `dout_en` in the same cycle and ends the burst. No further word is presented.
- R12: An access with `aux_space` high at the capture edge returns one word, from the captured address, after the very next edge, even in burst mode.
- R13: While `oe_n` is high, `dout_en` is low, but a running burst keeps advancing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_n | input | 1 | Chip select, active low |
| adv_n | input | 1 | Address-valid strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| aux_space | input | 1 | Access targets identifier/status/parameter space |
| addr | input | AW | Bus address |
| wdata | input | DW | Command data on writes |
| mem_addr | output | AW | Address to the storage array |
| mem_rdata | input | DW | Word returned by the storage array |
| dout | output | DW | Read data |
| dout_en | output | 1 | Read data is driven (high-impedance otherwise) |

## Verification
The hardest case to reach is the address capture by the strobe's rising edge. It needs an address-valid pulse that opens and closes entirely between two clock edges, while the address changes right after the pulse. The stimulus drives the pulse one and two nanoseconds after an edge and then corrupts the address, so only the value taken at the rising edge can give the expected words.

The companion case holds the strobe low across two edges with a different address on the second edge. This shows that only the first edge starts the burst.

// File: rtl/brs_pkg.sv
`timescale 1ns/1ps
package brs_pkg;

   // Read configuration register layout (bit 0 at the bottom)
   typedef struct packed {
      logic [2:0] lat;     // clocks to the first word
      logic [1:0] len;     // 00 four, 01 eight, 1x continuous
      logic       order;   // 1 = interleaved
      logic       sync;    // 1 = burst mode
   } rcfg_t;

   localparam int CFG_W = $bits(rcfg_t);

   localparam logic [7:0] CMD_SETUP   = 8'h60;
   localparam logic [7:0] CMD_CONFIRM = 8'h03;

   typedef enum logic [1:0] {
      B_IDLE = 2'd0,
      B_WAIT = 2'd1,
      B_STRM = 2'd2
   } bst_t;

   function automatic logic [2:0] clamp_lat(input logic [2:0] v,
                                            input int lo, input int hi);
      if (int'(v) < lo)      return 3'(lo);
      else if (int'(v) > hi) return 3'(hi);
      else                   return v;
   endfunction

endpackage

// File: rtl/brs_cfg_reg.sv
`timescale 1ns/1ps
module brs_cfg_reg
   import brs_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [DW-1:0]     wdata,
   input  logic [CFG_W-1:0]  cfg_bits,
   output rcfg_t             cfg
);

   logic armed_q;
   logic is_setup, is_confirm;

   assign is_setup   = (wdata == DW'(CMD_SETUP));
   assign is_confirm = (wdata == DW'(CMD_CONFIRM));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         cfg     <= '0;
      end else if (wr_stb) begin
         if (armed_q && is_confirm) begin
            cfg     <= rcfg_t'(cfg_bits);
            armed_q <= 1'b0;
         end else begin
            armed_q <= is_setup;
         end
      end
   end

   // R2: no write cycle, no configuration change
   assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb |=> $stable(cfg));

endmodule

// File: rtl/brs_addr_latch.sv
`timescale 1ns/1ps
module brs_addr_latch #(
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv_n,
   input  logic          accept,
   input  logic [AW-1:0] addr,
   output logic          start,
   output logic [AW-1:0] start_addr
);

   // Strobe-edge side: address taken on the rising edge of adv_n
   logic [AW-1:0] stash_q;
   logic          tog_q;

   always_ff @(posedge adv_n or negedge rst_n) begin
      if (!rst_n) begin
         stash_q <= '0;
         tog_q   <= 1'b0;
      end else begin
         stash_q <= addr;
         tog_q   <= ~tog_q;
      end
   end

   // Clock side
   logic seen_q, phase_hit_q;
   logic rise_evt, hit_clk, hit_rise;

   assign rise_evt = (tog_q != seen_q);
   assign hit_rise = rise_evt && !phase_hit_q && accept;
   assign hit_clk  = accept && !adv_n && !phase_hit_q && !rise_evt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q      <= 1'b0;
         phase_hit_q <= 1'b0;
      end else begin
         seen_q <= tog_q;
         if (hit_clk)
            phase_hit_q <= 1'b1;
         else if (rise_evt || adv_n)
            phase_hit_q <= 1'b0;
      end
   end

   assign start      = hit_clk || hit_rise;
   assign start_addr = hit_clk ? addr : stash_q;

   // R4: an edge capture blocks another one on the following edge
   assert_first_edge_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
      hit_clk |=> !hit_clk);

   // R5: a strobe-edge capture never coincides with a clock capture
   assert_one_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({hit_clk, hit_rise}));

endmodule

// File: rtl/brs_beat_gen.sv
`timescale 1ns/1ps
module brs_beat_gen
   import brs_pkg::*;
#(
   parameter int AW            = 16,
   parameter int LAT_MIN       = 2,
   parameter int LAT_MAX       = 6,
   parameter bit INTERLEAVE_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW-1:0] start_addr,
   input  logic          aux,
   input  rcfg_t         cfg,
   input  logic          halt,
   output logic          fetch,
   output logic [AW-1:0] fetch_addr,
   output logic          busy
);

   localparam logic [AW-1:0] MASK4 = AW'(3);
   localparam logic [AW-1:0] MASK8 = AW'(7);

   bst_t          st_q;
   logic [AW-1:0] base_q, beat_q;
   logic [2:0]    lat_q;
   logic          cont_q, wide_q, ilv_q, single_q;

   logic [AW-1:0] mask, lin_addr, lin_off, ilv_off, off;
   logic          last_beat;

   assign mask     = wide_q ? MASK8 : MASK4;
   assign lin_addr = base_q + beat_q;
   assign lin_off  = lin_addr & mask;
   assign ilv_off  = (base_q ^ beat_q) & mask;

   generate
      if (INTERLEAVE_EN) begin : g_ilv
         assign off = ilv_q ? ilv_off : lin_off;
      end else begin : g_lin_only
         logic unused_ilv;
         assign unused_ilv = ilv_q ^ (|ilv_off);
         assign off = lin_off;
      end
   endgenerate

   assign fetch_addr = (cont_q || single_q) ? lin_addr : ((base_q & ~mask) | off);
   assign last_beat  = single_q || (!cont_q && (beat_q == mask));
   assign fetch      = ((st_q == B_WAIT) && (lat_q == 3'd1)) || (st_q == B_STRM);
   assign busy       = (st_q != B_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= B_IDLE;
         base_q   <= '0;
         beat_q   <= '0;
         lat_q    <= '0;
         cont_q   <= 1'b0;
         wide_q   <= 1'b0;
         ilv_q    <= 1'b0;
         single_q <= 1'b0;
      end else if (halt) begin
         st_q <= B_IDLE;
      end else if (start) begin
         st_q     <= B_WAIT;
         base_q   <= start_addr;
         beat_q   <= '0;
         lat_q    <= aux ? 3'd1 : clamp_lat(cfg.lat, LAT_MIN, LAT_MAX);
         single_q <= aux;
         cont_q   <= cfg.len[1];
         wide_q   <= (cfg.len == 2'b01);
         ilv_q    <= cfg.order;
      end else begin
         unique case (st_q)
            B_WAIT: begin
               if (lat_q == 3'd1) begin
                  beat_q <= beat_q + AW'(1);
                  st_q   <= last_beat ? B_IDLE : B_STRM;
               end else begin
                  lat_q <= lat_q - 3'd1;
               end
            end
            B_STRM: begin
               beat_q <= beat_q + AW'(1);
               if (last_beat) st_q <= B_IDLE;
            end
            default: st_q <= B_IDLE;
         endcase
      end
   end

   // R10: a fixed burst never runs past its last word
   assert_fixed_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == B_STRM && !cont_q && !single_q) |-> (beat_q <= mask));

   // R11: a halt leaves the engine idle
   assert_halt_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      halt |=> !busy);

   // R12: an auxiliary access fetches exactly once
   assert_aux_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch && single_q) |=> !fetch);

endmodule

// File: rtl/burst_read_seq.sv
`timescale 1ns/1ps
module burst_read_seq
   import brs_pkg::*;
#(
   parameter int AW            = 16,
   parameter int DW            = 16,
   parameter int LAT_MIN       = 2,
   parameter int LAT_MAX       = 6,
   parameter bit INTERLEAVE_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sel_n,
   input  logic          adv_n,
   input  logic          oe_n,
   input  logic          we_n,
   input  logic          aux_space,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [AW-1:0] mem_addr,
   input  logic [DW-1:0] mem_rdata,
   output logic [DW-1:0] dout,
   output logic          dout_en
);

   generate
      if (AW < 8) begin : g_bad_aw
         $error("burst_read_seq: AW must be at least 8");
      end
      if (DW < 8) begin : g_bad_dw
         $error("burst_read_seq: DW must be at least 8");
      end
      if (LAT_MIN < 1 || LAT_MAX > 7 || LAT_MIN > LAT_MAX) begin : g_bad_lat
         $error("burst_read_seq: latency bounds out of range");
      end
   endgenerate

   rcfg_t         cfg;
   logic          wr_stb, accept, cap, burst_start, halt;
   logic [AW-1:0] cap_addr, beat_addr;
   logic          fetch, busy;
   logic          valid_q;

   assign wr_stb = !sel_n && !we_n && oe_n;
   assign accept = !sel_n && we_n;
   assign halt   = sel_n || wr_stb;

   brs_cfg_reg #(.DW(DW)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_stb   (wr_stb),
      .wdata    (wdata),
      .cfg_bits (addr[CFG_W-1:0]),
      .cfg      (cfg)
   );

   brs_addr_latch #(.AW(AW)) u_latch (
      .clk        (clk),
      .rst_n      (rst_n),
      .adv_n      (adv_n),
      .accept     (accept),
      .addr       (addr),
      .start      (cap),
      .start_addr (cap_addr)
   );

   assign burst_start = cap && cfg.sync;

   brs_beat_gen #(
      .AW            (AW),
      .LAT_MIN       (LAT_MIN),
      .LAT_MAX       (LAT_MAX),
      .INTERLEAVE_EN (INTERLEAVE_EN)
   ) u_beat (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (burst_start),
      .start_addr (cap_addr),
      .aux        (aux_space),
      .cfg        (cfg),
      .halt       (halt),
      .fetch      (fetch),
      .fetch_addr (beat_addr),
      .busy       (busy)
   );

   assign mem_addr = cfg.sync ? beat_addr : addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         dout    <= '0;
      end else if (sel_n) begin
         valid_q <= 1'b0;
      end else if (!cfg.sync) begin
         valid_q <= we_n;
         dout    <= mem_rdata;
      end else begin
         valid_q <= fetch;
         if (fetch) dout <= mem_rdata;
      end
   end

   assign dout_en = valid_q && !sel_n && !oe_n;

   // R11: deselecting clears the registered word-valid flag
   assert_sel_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sel_n) |=> !valid_q);

   // R3: plain read mode never has a burst in flight
   assert_async_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg.sync |-> !busy);

endmodule

// File: tb/burst_read_seq_test.sv
`timescale 1ns/1ps
module burst_read_seq_test;

   localparam int AW = 16;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sel_n = 1'b1, adv_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
   logic          aux_space = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_rdata;
   logic [DW-1:0] dout;
   logic          dout_en;

   int compared = 0, mismatched = 0, cyc = 0;
   bit done = 1'b0;

   logic [DW-1:0] exp_data[$];
   int            exp_cyc[$];
   string         exp_req[$];

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [DW-1:0] word_at(input logic [AW-1:0] a);
      return DW'(a * 16'd3) ^ 16'h5A5A;
   endfunction

   assign mem_rdata = word_at(mem_addr);

   burst_read_seq uut (
      .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .adv_n(adv_n), .oe_n(oe_n),
      .we_n(we_n), .aux_space(aux_space), .addr(addr), .wdata(wdata),
      .mem_addr(mem_addr), .mem_rdata(mem_rdata), .dout(dout), .dout_en(dout_en)
   );

   function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] s, input int k,
                                                input bit wide, input bit ilv, input bit cont);
      logic [AW-1:0] m, o;
      m = wide ? AW'(7) : AW'(3);
      if (cont) return s + AW'(k);
      o = ilv ? ((s ^ AW'(k)) & m) : ((s + AW'(k)) & m);
      return (s & ~m) | o;
   endfunction

   task automatic push(input logic [DW-1:0] d, input int c, input string req);
      exp_data.push_back(d);
      exp_cyc.push_back(c);
      exp_req.push_back(req);
   endtask

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && dout_en) begin
         compared++;
         if (exp_data.size() == 0) begin
            mismatched++;
            $display("FAIL unexpected word at cycle %0d: actual %0h expected none", cyc, dout);
         end else begin
            logic [DW-1:0] d;
            int            c;
            string         r;
            d = exp_data.pop_front();
            c = exp_cyc.pop_front();
            r = exp_req.pop_front();
            if (dout !== d || cyc != c) begin
               mismatched++;
               $display("FAIL %s: actual %0h@%0d expected %0h@%0d", r, dout, cyc, d, c);
            end
         end
      end
   end

   task automatic drained(input string req);
      check(exp_data.size() == 0, req, "words still expected", exp_data.size(), 0);
      exp_data.delete(); exp_cyc.delete(); exp_req.delete();
   endtask

   task automatic write_cfg(input logic [7:0] second, input logic [6:0] val);
      sel_n = 0; we_n = 0; oe_n = 1; wdata = 16'h0060; addr = '0;
      @(posedge clk); #1;
      wdata = {8'h00, second}; addr = {9'h000, val};
      @(posedge clk); #1;
      we_n = 1; sel_n = 1; wdata = '0;
      @(posedge clk); #1;
   endtask

   // mode 0: clock capture, 1: strobe pulse between edges, 2: strobe held over two edges
   task automatic start_read(input logic [AW-1:0] a, input int mode, output int cap);
      sel_n = 0; oe_n = 0; addr = a;
      if (mode == 1) begin
         adv_n = 0; #1; adv_n = 1; #1; addr = 16'hDEAD;
         @(posedge clk); #1; cap = cyc;
      end else begin
         adv_n = 0;
         @(posedge clk); #1; cap = cyc; addr = 16'hBEEF;
         if (mode == 2) begin
            @(posedge clk); #1;
         end
         adv_n = 1;
      end
   endtask

   task automatic fixed_burst(input logic [AW-1:0] a, input int mode, input int lat,
                              input bit wide, input bit ilv, input string req);
      int cap, n;
      n = wide ? 8 : 4;
      start_read(a, mode, cap);
      for (int k = 0; k < n; k++)
         push(word_at(beat_addr(a, k, wide, ilv, 1'b0)), cap + lat + k, req);
      while (cyc < cap + lat + n) begin
         @(posedge clk); #1;
      end
      // R10: after the last word the output turns off while still selected
      check(dout_en == 1'b0, "R10", "dout_en after last word", dout_en, 0);
      sel_n = 1; oe_n = 1;
      @(posedge clk); #1;
      drained(req);
   endtask

   initial begin
      int cap;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      @(negedge clk);
      // R1: outputs off after reset
      check(dout_en == 1'b0, "R1", "dout_en after reset", dout_en, 0);
      @(posedge clk); #1;

      // R1/R3: default plain read mode, one word per clock
      sel_n = 0; oe_n = 0;
      for (int i = 0; i < 4; i++) begin
         addr = AW'(16'h0040 + i * 9);
         @(posedge clk); #1;
         push(word_at(addr), cyc, "R3");
      end
      @(negedge clk); #1;
      sel_n = 1; oe_n = 1;
      @(posedge clk); #1;
      drained("R3");

      // R2/R7/R4/R6: burst, linear, four words, latency 2
      write_cfg(8'h03, 7'h21);
      fixed_burst(16'h0106, 0, 2, 1'b0, 1'b0, "R7");

      // R8: interleaved, eight words, latency 3
      write_cfg(8'h03, 7'h37);
      fixed_burst(16'h02B3, 0, 3, 1'b1, 1'b1, "R8");

      // R7: linear, eight words, latency 4
      write_cfg(8'h03, 7'h45);
      fixed_burst(16'h00FD, 0, 4, 1'b1, 1'b0, "R7");

      // R9/R11: continuous, latency 5, crossing 0x100, then deselect
      write_cfg(8'h03, 7'h59);
      start_read(16'h00FE, 0, cap);
      for (int k = 0; k < 10; k++)
         push(word_at(16'h00FE + AW'(k)), cap + 5 + k, "R9");
      while (cyc < cap + 5 + 10) begin
         @(posedge clk); #1;
      end
      sel_n = 1;
      #1;
      check(dout_en == 1'b0, "R11", "dout_en right after deselect", dout_en, 0);
      oe_n = 1;
      repeat (4) @(posedge clk);
      #1;
      drained("R11");

      // R6 clamp high (7 -> 6) with R5 strobe-edge capture
      write_cfg(8'h03, 7'h71);
      fixed_burst(16'h0312, 1, 6, 1'b0, 1'b0, "R5");

      // R6 clamp low (0 -> 2) with R4 strobe held over two edges
      write_cfg(8'h03, 7'h01);
      fixed_burst(16'h0421, 2, 2, 1'b0, 1'b0, "R4");

      // R12: auxiliary access in burst mode yields one word after one edge
      aux_space = 1;
      start_read(16'h0777, 0, cap);
      aux_space = 0;
      push(word_at(16'h0777), cap + 1, "R12");
      repeat (6) @(posedge clk);
      #1;
      check(dout_en == 1'b0, "R12", "no second word", dout_en, 0);
      sel_n = 1; oe_n = 1;
      @(posedge clk); #1;
      drained("R12");

      // R13: output disabled during first word, burst keeps advancing
      write_cfg(8'h03, 7'h21);
      start_read(16'h0508, 0, cap);
      oe_n = 1;
      for (int k = 1; k < 4; k++)
         push(word_at(beat_addr(16'h0508, k, 1'b0, 1'b0, 1'b0)), cap + 2 + k, "R13");
      while (cyc < cap + 3) begin
         @(posedge clk); #1;
      end
      oe_n = 0;
      repeat (5) @(posedge clk);
      #1;
      sel_n = 1; oe_n = 1;
      @(posedge clk); #1;
      drained("R13");

      // R2: a wrong second write leaves the burst configuration in place
      write_cfg(8'hFF, 7'h00);
      fixed_burst(16'h0A0B, 0, 2, 1'b0, 1'b0, "R2");

      // R2: a proper write returns to plain read mode
      write_cfg(8'h03, 7'h00);
      sel_n = 0; oe_n = 0;
      for (int i = 0; i < 3; i++) begin
         addr = AW'(16'h1230 + i);
         @(posedge clk); #1;
         push(word_at(addr), cyc, "R2");
      end
      @(negedge clk); #1;
      sel_n = 1; oe_n = 1;
      @(posedge clk); #1;
      drained("R2");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         compared++;
         mismatched++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

endmodule